// File: doc/BRIEF.md
# Gapless Store-and-Forward Transmit Streamer

This block sits between a bursty packet source and a 64-bit streaming transmit port of a serial link core. Each input beat carries two 32-bit doublewords along with start and end markers. The block holds beats in an internal buffer and does not release a packet until its final beat is stored. Once a packet is released, it goes out with no idle beats that the streamer causes itself. This matters because the sink treats a valid-low cycle inside a packet as corruption, unless that cycle follows the sink withdrawing ready.

The sink uses a ready signal with a fixed reaction latency `RDY_LAT` (1 to 3 cycles). On the output side, a beat is presented with valid high in cycle t only if `tx_ready` was high in cycle t-`RDY_LAT`. Every beat presented with valid high counts as taken by the sink. When `tx_ready` falls, the streamer therefore sends exactly the beats already committed within the latency window. It then stops, and when ready returns it resumes from the next beat.

The output side is a two-state machine. TX_IDLE waits for a complete packet. The start transition moves it to TX_SEND once the complete-packet count is nonzero. TX_SEND presents one beat per cycle while the delayed ready is high. On the last beat it takes the chain transition and stays in TX_SEND if another complete packet is already buffered. Otherwise it takes the done transition back to TX_IDLE. A synchronous active-high reset empties the buffer and forces both the state machine and the ready history to idle.

Top module: `gapless_tx_streamer`

## Requirements
- R1: During and after a synchronous reset, `tx_valid` is low and `in_ready` is high, and the buffer holds no beats.
- R2: `in_ready` is low exactly when the buffer holds `DEPTH` beats. A beat is taken when `in_valid` and `in_ready` are both high, and no taken beat is ever lost.
- R3: No beat of a packet is presented on the output before the packet's end-marked beat has been taken at the input.
- R4: Output beats carry the input's 64-bit data unchanged, with doubleword lanes kept in place (bits [31:0] and [63:32]). For example, a three-doubleword-header packet leaves as {H1,H0} then {D0,H2}. `tx_sop` and `tx_eop` mark the first and last beat.
- R5: Between the start beat and the end beat of a packet, `tx_valid` is high in every cycle t for which `tx_ready` was high in cycle t-`RDY_LAT`.
- R6: `tx_valid` is high in cycle t only if `tx_ready` was high in cycle t-`RDY_LAT`. After `tx_ready` falls, at most `RDY_LAT` further beats are presented.
- R7: Every beat presented with `tx_valid` high counts as taken by the sink. Beats leave in the order they arrived, with none skipped or repeated across ready pauses.
- R8: When another complete packet is already buffered at the end beat of a packet, the next packet's start beat follows in the very next cycle that the delayed ready allows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source beat valid |
| in_ready | output | 1 | Buffer can take a beat |
| in_data | input | DATA_W | Source beat data, two doublewords |
| in_sop | input | 1 | Source beat is first of packet |
| in_eop | input | 1 | Source beat is last of packet |
| tx_valid | output | 1 | Output beat valid; every valid beat is taken |
| tx_ready | input | 1 | Sink ready, acted on `RDY_LAT` cycles later |
| tx_data | output | DATA_W | Output beat data |
| tx_sop | output | 1 | Output beat is first of packet |
| tx_eop | output | 1 | Output beat is last of packet |

## Verification
The embedded assertions watch three rules on every cycle: valid never rises without ready having been high `RDY_LAT` cycles earlier, valid never drops inside a packet while that delayed ready is high, and start markers appear only on the first beat of each packet. They also catch buffer overflow and underflow, and any release of a packet that is not complete. Data integrity and lane order need the bench's behavioural model, compared every clock, to be shown. The same holds for the exact number of beats sent after ready falls, the hold-off on an incomplete packet, and back-to-back chaining of stored packets.

// File: rtl/gtx_pkg.sv
package gtx_pkg;
    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;
endpackage

// File: rtl/gtx_beat_buffer.sv
module gtx_beat_buffer #(
    parameter int BEAT_W = 66,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BEAT_W-1:0] wr_beat,
    input  logic              rd_en,
    output logic [BEAT_W-1:0] head,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [BEAT_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp;
    logic [AW-1:0]     rp;
    logic [CW-1:0]     cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= bump(wp);
            if (rd_en) rp <= bump(rp);
            unique case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R2: a write never lands on a full buffer
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);
    // R7: a read never takes from an empty buffer
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);
endmodule

// File: rtl/gtx_pkt_counter.sv
module gtx_pkt_counter #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt
);
    always_comb begin
        unique case ({inc, dec})
            2'b10:   count_nxt = count + CW'(1);
            2'b01:   count_nxt = count - CW'(1);
            default: count_nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nxt;
    end

    // R3: an end beat only leaves when a complete packet was counted
    assert_start_complete_R3: assert property (@(posedge clk) disable iff (rst)
        dec |-> (count != '0));
endmodule

// File: rtl/gtx_ready_pipe.sv
module gtx_ready_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rdy_in,
    output logic rdy_dly
);
    logic [LAT-1:0] pipe;

    generate
        if (LAT == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= rdy_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[LAT-2:0], rdy_in};
            end
        end
    endgenerate

    assign rdy_dly = pipe[LAT-1];
endmodule

// File: rtl/gtx_tx_fsm.sv
module gtx_tx_fsm
    import gtx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pkt_avail,
    input  logic pkt_more,
    input  logic rdy_dly,
    input  logic head_eop,
    input  logic buf_empty,
    output logic tx_valid,
    output logic rd_en
);
    tx_state_e state;
    tx_state_e state_nxt;

    // next-state: start, chain, done
    always_comb begin
        state_nxt = state;
        unique case (state)
            TX_IDLE: if (pkt_avail) state_nxt = TX_SEND;
            TX_SEND: if (rdy_dly && head_eop)
                         state_nxt = pkt_more ? TX_SEND : TX_IDLE;
            default: state_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TX_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            TX_SEND: tx_valid = rdy_dly;
            default: tx_valid = 1'b0;
        endcase
        rd_en = tx_valid;
    end

    // R3: sending only happens with stored beats behind it
    assert_send_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
        (state == TX_SEND) |-> !buf_empty);
endmodule

// File: rtl/gapless_tx_streamer.sv
module gapless_tx_streamer #(
    parameter int DATA_W  = 64,
    parameter int DEPTH   = 16,
    parameter int RDY_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_sop,
    output logic              tx_eop
);
    localparam int BEAT_W = DATA_W + 2;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              buf_full;
    logic              buf_empty;
    logic              wr_en;
    logic              rd_en;
    logic              rdy_dly;
    logic              pkt_inc;
    logic              pkt_dec;
    logic [BEAT_W-1:0] head;
    logic [CNT_W-1:0]  pkt_cnt;
    logic [CNT_W-1:0]  pkt_cnt_nxt;

    assign in_ready = !buf_full;
    assign wr_en    = in_valid && in_ready;
    assign tx_data  = head[DATA_W-1:0];
    assign tx_eop   = head[DATA_W];
    assign tx_sop   = head[DATA_W+1];
    assign pkt_inc  = wr_en && in_eop;
    assign pkt_dec  = rd_en && tx_eop;

    gtx_beat_buffer #(.BEAT_W(BEAT_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_beat({in_sop, in_eop, in_data}),
        .rd_en(rd_en), .head(head),
        .full(buf_full), .empty(buf_empty)
    );

    gtx_pkt_counter #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .inc(pkt_inc), .dec(pkt_dec),
        .count(pkt_cnt), .count_nxt(pkt_cnt_nxt)
    );

    gtx_ready_pipe #(.LAT(RDY_LAT)) u_rdy (
        .clk(clk), .rst(rst),
        .rdy_in(tx_ready), .rdy_dly(rdy_dly)
    );

    gtx_tx_fsm u_fsm (
        .clk(clk), .rst(rst),
        .pkt_avail(pkt_cnt != '0), .pkt_more(pkt_cnt_nxt != '0),
        .rdy_dly(rdy_dly), .head_eop(tx_eop), .buf_empty(buf_empty),
        .tx_valid(tx_valid), .rd_en(rd_en)
    );

    // port-level observers for the protocol assertions
    logic [1:0] hi_run;
    logic [1:0] lo_run;
    logic       in_pkt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run <= '0;
            lo_run <= '0;
            in_pkt <= 1'b0;
        end else begin
            hi_run <= tx_ready ? ((hi_run == 2'd3) ? hi_run : hi_run + 2'd1) : 2'd0;
            lo_run <= tx_ready ? 2'd0 : ((lo_run == 2'd3) ? lo_run : lo_run + 2'd1);
            if (tx_valid && tx_eop)       in_pkt <= 1'b0;
            else if (tx_valid && tx_sop)  in_pkt <= 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!tx_valid && in_ready));
    assert_valid_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (lo_run >= 2'(RDY_LAT)) |-> !tx_valid);
    assert_no_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (in_pkt && hi_run >= 2'(RDY_LAT)) |-> tx_valid);
    assert_sop_first_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !in_pkt) |-> tx_sop);
    assert_sop_inside_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && in_pkt) |-> !tx_sop);
endmodule

// File: tb/gapless_tx_streamer_tb.sv
`timescale 1ns/1ps
module gapless_tx_streamer_tb;
    localparam int DW    = 64;
    localparam int DEPTH = 16;
    localparam int LAT   = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          in_ready;
    logic [DW-1:0] in_data;
    logic          in_sop;
    logic          in_eop;
    logic          tx_valid;
    logic          tx_ready;
    logic [DW-1:0] tx_data;
    logic          tx_sop;
    logic          tx_eop;

    always #4 clk = ~clk;

    gapless_tx_streamer #(.DATA_W(DW), .DEPTH(DEPTH), .RDY_LAT(LAT)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eop(tx_eop)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [65:0] src[$];
    bit [65:0] mq[$];
    bit [65:0] sent_log[$];
    bit [65:0] recv_log[$];
    int        m_pkts = 0;
    bit        m_send = 0;
    bit [3:0]  m_rh = '0;
    int        in_prob = 100;
    int        rdy_mode = 0;
    bit        obs_v;
    int        cyc = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step();
        bit exp_ir, exp_v, acc_in, wr, rd, hd_eop;
        int pn;
        @(negedge clk);
        if (src.size() > 0 && $urandom_range(99) < in_prob) begin
            in_valid = 1'b1;
            {in_sop, in_eop, in_data} = src[0];
        end else begin
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        end
        case (rdy_mode)
            0:       tx_ready = 1'b0;
            1:       tx_ready = 1'b1;
            2:       tx_ready = 1'($urandom_range(1));
            default: tx_ready = ($urandom_range(99) < 80);
        endcase
        #1;
        exp_ir = (mq.size() < DEPTH);
        exp_v  = m_send && m_rh[LAT-1];
        if (!rst) begin
            chk(in_ready == exp_ir, "R2 in_ready", 66'(in_ready), 66'(exp_ir));
            chk(tx_valid == exp_v, "R3 R5 R6 tx_valid", 66'(tx_valid), 66'(exp_v));
            if (exp_v && tx_valid && mq.size() > 0) begin
                chk(tx_data == mq[0][63:0], "R4 R7 tx_data", 66'(tx_data), 66'(mq[0][63:0]));
                chk({tx_sop, tx_eop} == mq[0][65:64], "R4 markers",
                    66'({tx_sop, tx_eop}), 66'(mq[0][65:64]));
            end
        end
        obs_v = tx_valid;
        if (tx_valid) recv_log.push_back({tx_sop, tx_eop, tx_data});
        acc_in = in_valid && in_ready;
        @(posedge clk);
        if (rst) begin
            mq.delete(); m_pkts = 0; m_send = 0; m_rh = '0;
        end else begin
            wr = in_valid && exp_ir;
            rd = exp_v;
            hd_eop = (rd && mq.size() > 0) ? mq[0][64] : 1'b0;
            if (rd && mq.size() > 0) void'(mq.pop_front());
            if (wr) mq.push_back({in_sop, in_eop, in_data});
            pn = m_pkts + int'(wr && in_eop) - int'(hd_eop);
            if (!m_send) m_send = (m_pkts != 0);
            else if (hd_eop) m_send = (pn != 0);
            m_pkts = pn;
            m_rh = {m_rh[2:0], tx_ready};
        end
        if (acc_in && !rst) begin
            sent_log.push_back(src[0]);
            void'(src.pop_front());
        end
        cyc++;
    endtask

    task automatic add_pkt(input int beats, input bit [31:0] tag);
        for (int b = 0; b < beats; b++)
            src.push_back({b == 0, b == beats - 1, tag + 32'(2*b + 1), tag + 32'(2*b)});
    endtask

    task automatic drain();
        for (int i = 0; i < 5000; i++) begin
            if (src.size() == 0 && mq.size() == 0 && !m_send) break;
            step();
        end
        repeat (4) step();
    endtask

    task automatic wait_src();
        for (int i = 0; i < 2000; i++) begin
            if (src.size() == 0) break;
            step();
        end
        repeat (3) step();
    endtask

    initial begin
        int base, cnt, first_i, last_i;
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        in_data = '0; tx_ready = 1'b0;
        repeat (3) step();
        // R1: reset state, including while reset is held
        chk(tx_valid == 1'b0, "R1 tx_valid in reset", 66'(tx_valid), 66'(0));
        chk(in_ready == 1'b1, "R1 in_ready in reset", 66'(in_ready), 66'(1));
        rst = 1'b0;
        step();
        chk(tx_valid == 1'b0, "R1 tx_valid after reset", 66'(tx_valid), 66'(0));
        chk(in_ready == 1'b1, "R1 in_ready after reset", 66'(in_ready), 66'(1));

        // R4: three-doubleword header packet lanes {H1,H0},{D0,H2}
        rdy_mode = 1;
        base = recv_log.size();
        src.push_back({1'b1, 1'b0, 32'hA1A1_0001, 32'hA0A0_0000});
        src.push_back({1'b0, 1'b1, 32'hD0D0_0003, 32'hA2A2_0002});
        drain();
        chk(recv_log.size() == base + 2, "R4 beat count", 66'(recv_log.size() - base), 66'(2));
        if (recv_log.size() == base + 2) begin
            chk(recv_log[base][31:0] == 32'hA0A0_0000, "R4 H0 lane", 66'(recv_log[base][31:0]), 66'hA0A0_0000);
            chk(recv_log[base][63:32] == 32'hA1A1_0001, "R4 H1 lane", 66'(recv_log[base][63:32]), 66'hA1A1_0001);
            chk(recv_log[base+1][31:0] == 32'hA2A2_0002, "R4 H2 lane", 66'(recv_log[base+1][31:0]), 66'hA2A2_0002);
            chk(recv_log[base+1][63:32] == 32'hD0D0_0003, "R4 D0 lane", 66'(recv_log[base+1][63:32]), 66'hD0D0_0003);
        end

        // R3: incomplete packet is held back
        add_pkt(4, 32'h3000_0000);
        begin
            bit [65:0] last_beat;
            last_beat = src[3];
            void'(src.pop_back());
            wait_src();
            cnt = 0;
            repeat (8) begin step(); if (obs_v) cnt++; end
            chk(cnt == 0, "R3 held until end beat", 66'(cnt), 66'(0));
            src.push_back(last_beat);
        end
        drain();

        // R6: beats after ready falls equal the latency
        rdy_mode = 0;
        add_pkt(12, 32'h6000_0000);
        wait_src();
        rdy_mode = 1;
        repeat (5) step();
        rdy_mode = 0;
        cnt = 0;
        repeat (6) begin step(); if (obs_v) cnt++; end
        chk(cnt == LAT, "R6 beats after ready drop", 66'(cnt), 66'(LAT));
        rdy_mode = 1;
        drain();

        // R8: stored single-beat packets leave back to back
        rdy_mode = 0;
        for (int k = 0; k < 4; k++) add_pkt(1, 32'h8000_0000 + 32'(k * 16));
        wait_src();
        rdy_mode = 1;
        cnt = 0; first_i = -1; last_i = -1;
        for (int i = 0; i < 10; i++) begin
            step();
            if (obs_v) begin cnt++; if (first_i < 0) first_i = i; last_i = i; end
        end
        chk(cnt == 4, "R8 packets sent", 66'(cnt), 66'(4));
        chk(last_i - first_i == 3, "R8 no gap between packets", 66'(last_i - first_i), 66'(3));
        drain();

        // R2: buffer fills and back-pressures the source
        rdy_mode = 0;
        for (int k = 0; k < 3; k++) add_pkt(8, 32'h2000_0000 + 32'(k * 256));
        repeat (30) step();
        chk(in_ready == 1'b0, "R2 in_ready low when full", 66'(in_ready), 66'(0));
        chk(src.size() == 8, "R2 beats left at source", 66'(src.size()), 66'(8));
        rdy_mode = 1;
        drain();

        // R5 R7: random traffic with ready pauses
        in_prob = 60;
        for (int g = 0; g < 6; g++) begin
            rdy_mode = (g % 2 == 0) ? 2 : 3;
            for (int k = 0; k < 50; k++)
                add_pkt($urandom_range(DEPTH, 1), 32'($urandom));
            drain();
        end
        rdy_mode = 1;
        drain();

        // R7: end-to-end order, nothing lost or repeated
        chk(recv_log.size() == sent_log.size(), "R7 beat totals",
            66'(recv_log.size()), 66'(sent_log.size()));
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < sent_log.size() && i < recv_log.size(); i++)
                if (recv_log[i] != sent_log[i]) bad++;
            chk(bad == 0, "R7 beat order", 66'(bad), 66'(0));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule